// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of equal, even width and returns the full signed product at twice that width. The multiplier operand is cut into overlapping three-bit windows, one per pair of bits, with an implied zero below the least significant bit. Each window becomes one digit from the set {-2, -1, 0, +1, +2}, so there are half as many partial-product rows as operand bits. Each row is the multiplicand selected as zero, itself or doubled, and then inverted when the digit is negative. Rows for higher digits sit two bit positions further left.

No row is sign-extended across the product width. The sign bit of each row is inverted. One fixed constant word, with a 1 at the first row's top position and a 1 just above the top of every row, stands in for all the missing extension bits. The +1 that completes each negation goes into a correction word at the least significant position of that row. All rows, the constant and the correction word go through one plain adder chain, and any carry beyond the product width is dropped.

A parameter selects an output register. With the register enabled (the default), a high `validIn` loads the product on the next rising edge and raises `validOut` for that cycle. While `validIn` is low the register holds its last product. With the register disabled, the product is purely combinational and `validOut` follows `validIn`.

Top module: `booth_mult`

## Requirements
- R1: For any operands, `product` equals the signed product of `multiplicand` and `multiplier`, both taken as two's complement, given as a 2*WIDTH-bit two's-complement value.
- R2: With the output register enabled, `validOut` is high in the cycle after a rising edge at which `validIn` was high, and low in the cycle after an edge at which `validIn` was low.
- R3: With the output register enabled, `product` keeps its value across an edge at which `validIn` is low, even when the operands change.
- R4: While `rstN` is low, `product` is all zeros and `validOut` is low.
- R5: A multiplicand of -2^(WIDTH-1), the most negative value, gives the exact product, including when it is doubled and negated.
- R6: A multiplier of -2^(WIDTH-1) gives the exact product; its top window recodes to the digit -2.
- R7: 11 times 19 gives 209. A multiplier of 7, recoded as +2 in the second digit and -1 in the first, gives seven times the multiplicand.
- R8: A zero in either operand gives a product of zero.
- R9: -1 times -1 gives +1, and -1 times any value v gives -v.
- R10: Operands presented with `validIn` high on consecutive cycles give one correct product per cycle, each one cycle after its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands are valid; loads the output register |
| multiplicand | input | WIDTH | Signed multiplicand |
| multiplier | input | WIDTH | Signed multiplier, Booth recoded |
| product | output | 2*WIDTH | Signed product |
| validOut | output | 1 | Product register holds a fresh result |

## Verification
With the default output register, each product and its `validOut` are due exactly one rising edge after the operands are sampled with `validIn` high. There is no further latency, because recoding, row forming and summation all happen within that one cycle. The bench changes inputs on falling edges and reads results on the next falling edge, so every comparison falls half a period after the capturing edge. The hold and valid-low checks read the outputs at the falling edge after an idle rising edge. The back-to-back test compares each result one falling edge after its operands were driven, while the next operands are already on the inputs.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One recoded radix-4 digit: magnitude select plus sign
  typedef struct packed {
    logic neg;    // digit is negative: invert row, add 1 at its LSB
    logic dbl;    // magnitude two: multiplicand shifted left once
    logic nz;     // digit is nonzero
  } digit_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the product register
  } strobe_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0] window,   // {y[2i+1], y[2i], y[2i-1]}
  output digit_t     digit
);

  always_comb begin
    case (window)
      3'b000:  digit = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};  //  0
      3'b001:  digit = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};  // +1
      3'b010:  digit = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};  // +1
      3'b011:  digit = '{neg: 1'b0, dbl: 1'b1, nz: 1'b1};  // +2
      3'b100:  digit = '{neg: 1'b1, dbl: 1'b1, nz: 1'b1};  // -2
      3'b101:  digit = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};  // -1
      3'b110:  digit = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};  // -1
      default: digit = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};  //  0
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    validIn,
  output strobe_t strobe,
  output logic    validOut
);

  assign strobe.capture = validIn;

  if (OUT_REG) begin : g_regValid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validOut <= 1'b0;
      else       validOut <= validIn;
    end
  end else begin : g_combValid
    assign validOut = validIn;
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int DIGITS = WIDTH / 2;
  localparam int PW     = 2 * WIDTH;

  // Replaces all sign extension: 1 at the first row's top bit (WIDTH),
  // and 1 just above the top bit of every row (WIDTH+1+2i).
  function automatic logic [PW-1:0] signConst();
    logic [PW-1:0] v;
    v = '0;
    v[WIDTH] = 1'b1;
    for (int i = 0; i < DIGITS; i++) v[WIDTH + 1 + 2*i] = 1'b1;
    return v;
  endfunction

  localparam logic [PW-1:0] SIGN_CONST = signConst();

  logic [WIDTH:0]   yExt;
  logic [WIDTH:0]   mcandExt;
  logic [WIDTH:0]   mcandDbl;
  digit_t           dig     [DIGITS];
  logic [WIDTH:0]   ppRow   [DIGITS];
  logic [PW-1:0]    rowVec  [DIGITS];
  logic [PW-1:0]    partial [DIGITS+1];
  logic [PW-1:0]    negCorr;
  logic [PW-1:0]    sumAll;

  assign yExt     = {multiplier, 1'b0};
  assign mcandExt = {multiplicand[WIDTH-1], multiplicand};
  assign mcandDbl = {multiplicand, 1'b0};

  for (genvar i = 0; i < DIGITS; i++) begin : g_row
    logic [WIDTH:0] mag;

    booth_recoder u_rec (
      .window (yExt[2*i+2 -: 3]),
      .digit  (dig[i])
    );

    always_comb begin
      if (!dig[i].nz)      mag = '0;
      else if (dig[i].dbl) mag = mcandDbl;
      else                 mag = mcandExt;
      ppRow[i] = dig[i].neg ? ~mag : mag;
    end

    // Sign bit inverted, no extension, aligned 2i to the left
    assign rowVec[i] = {{(PW-WIDTH-1){1'b0}}, ~ppRow[i][WIDTH], ppRow[i][WIDTH-1:0]} << (2*i);
  end

  always_comb begin
    negCorr = '0;
    for (int i = 0; i < DIGITS; i++) negCorr[2*i] = dig[i].neg;
  end

  // Plain adder chain, modulo 2^PW
  assign partial[0] = SIGN_CONST + negCorr;
  for (genvar i = 0; i < DIGITS; i++) begin : g_sum
    assign partial[i+1] = partial[i] + rowVec[i];
  end
  assign sumAll = partial[DIGITS];

  if (OUT_REG) begin : g_regOut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               product <= '0;
      else if (strobe.capture) product <= sumAll;
    end
  end else begin : g_combOut
    assign product = sumAll;
  end

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               validOut
);

  if (WIDTH % 2 != 0 || WIDTH < 2) begin : g_badWidth
    $error("booth_mult: WIDTH must be even and at least 2");
  end

  strobe_t strobe;

  booth_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  booth_datapath #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               validIn,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic [2*WIDTH-1:0] product,
  input logic               validOut
);

  logic signed [2*WIDTH-1:0] refProd;
  logic                      anyZero;

  always_comb begin
    refProd = $signed(multiplicand) * $signed(multiplier);
    anyZero = (multiplicand == '0) || (multiplier == '0);
  end

  if (OUT_REG) begin : g_regChk
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      validIn |=> validOut);  // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
      !validIn |=> !validOut);  // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !validIn |=> $stable(product));  // R3
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
      validIn |=> (product == $past(refProd)));  // R1
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
      (validIn && anyZero) |=> (product == '0));  // R8
  end else begin : g_combChk
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
      product == refProd);  // R1
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
      anyZero |-> (product == '0));  // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      validOut == validIn);  // R2
    AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({validOut, !validIn}));  // R2
  end

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) i_booth_mult_chk (
  .clk          (clk),
  .rstN         (rstN),
  .validIn      (validIn),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .product      (product),
  .validOut     (validOut)
);

// File: tb/test_booth_mult.sv
module test_booth_mult;

  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          validIn = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic [PW-1:0] product;
  logic          validOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  booth_mult #(.WIDTH(W), .OUT_REG(1'b1)) i_booth_mult (
    .clk          (clk),
    .rstN         (rstN),
    .validIn      (validIn),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .product      (product),
    .validOut     (validOut)
  );

  function automatic logic [PW-1:0] expProd(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    return sa * sb;
  endfunction

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, wait one edge, check both outputs
  task automatic applyOne(string req, logic [W-1:0] a, logic [W-1:0] b);
    mcand = a; mplier = b; validIn = 1'b1;
    @(negedge clk);
    check(req, product, expProd(a, b));
    check({req, " validOut"}, PW'(validOut), PW'(1'b1));
    validIn = 1'b0;
  endtask

  task automatic testReset();
    check("R4 product", product, '0);
    check("R4 validOut", PW'(validOut), '0);
  endtask

  task automatic testExamples();
    applyOne("R7 11x19", W'(11), W'(19));
    check("R7 value 209", product, PW'(209));
    applyOne("R7 x7", W'(1234), W'(7));
    applyOne("R7 neg x7", W'(-321), W'(7));
  endtask

  task automatic testZeros();
    applyOne("R8 zero mcand", '0, W'(12345));
    applyOne("R8 zero mplier", W'(-999), '0);
    applyOne("R8 both zero", '0, '0);
  endtask

  task automatic testMinusOne();
    applyOne("R9 -1x-1", '1, '1);
    check("R9 value +1", product, PW'(1));
    applyOne("R9 -1xv", '1, W'(4321));
    applyOne("R9 vx-1", W'(-77), '1);
  endtask

  task automatic testMostNeg();
    logic [W-1:0] mn = {1'b1, {(W-1){1'b0}}};
    applyOne("R5 minneg mcand x2", mn, W'(2));
    applyOne("R5 minneg mcand x-2", mn, W'(-2));
    applyOne("R5 minneg mcand x-1", mn, '1);
    applyOne("R6 minneg mplier", W'(3), mn);
    applyOne("R6 minneg both", mn, mn);
    applyOne("R6 minneg mplier xmax", {1'b0, {(W-1){1'b1}}}, mn);
  endtask

  task automatic testHold();
    logic [PW-1:0] held;
    applyOne("R3 setup", W'(100), W'(-5));
    held = product;
    mcand = W'(7); mplier = W'(9); validIn = 1'b0;
    @(negedge clk);
    check("R3 held product", product, held);
    check("R2 validOut low", PW'(validOut), '0);
  endtask

  task automatic testBackToBack();
    logic [W-1:0] pa, pb;
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      if (k > 0) begin
        check("R10 stream", product, expProd(pa, pb));
        check("R2 stream valid", PW'(validOut), PW'(1'b1));
      end
      mcand = a; mplier = b; validIn = 1'b1;
      pa = a; pb = b;
      @(negedge clk);
    end
    check("R10 stream last", product, expProd(pa, pb));
    validIn = 1'b0;
  endtask

  task automatic testRandom();
    for (int k = 0; k < 200; k++) begin
      applyOne("R1 random", W'($urandom), W'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testExamples();
    testZeros();
    testMinusOne();
    testMostNeg();
    testHold();
    testBackToBack();
    testRandom();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule